// File: doc/BRIEF.md
# Channel Power-Good and Undervoltage Mask Logic

This block handles one regulator channel. It decides when undervoltage (UV) faults and warnings may be reported. It also works out the channel's power-good state and drives two separate views of it: the control for an open-drain power-good pin, and a power-good bit for the status registers. Every input is a logic-level result. The voltage comparators, the sequencing timers and the overcurrent detector sit outside this block and pass their decisions in.

A role bit sets how the channel behaves. A master channel judges power good from its own output voltage, which must lie between the UV and OV limits. A slave channel follows the shared compensation node instead. When the master's error amplifier drives that node too high, the slave disables its output at once and raises its OV flag. During this fault it clears its status power-good bit but leaves the pin released. A 2-bit OV-response setting decides what happens after the fault clears. With the ignore setting, the slave re-enables its output as soon as the fault clears. With any other setting, the slave stays disabled until the channel is switched off and on again.

Every output is registered. The outputs therefore reflect the inputs sampled at the previous rising clock edge.

Top module: `pgood_uvmask`

## Requirements
- R1: While `run_en` is low, `uv_unmask` is 0 in the following cycle.
- R2: `uv_unmask` is 1 only when the following five conditions held at the previous edge, with `run_en` also high: `ton_dly_done` is high, `ton_rise_done` is high, `ton_max_done` is high, `oc_hit` is low, and `toff_fall_busy` is low. If any one of them is missing, `uv_unmask` is 0.
- R3: For a master (`is_master`=1), `pg_status` equals the previous cycle's `run_en & vout_above_uv & vout_below_ov`. A master ignores `ea_fault`, so `ov_flag` and `out_disable` stay 0.
- R4: For a master, `pgood_pull_low` is 1 whenever `pg_status` is 0, including when the channel is off.
- R5: A running slave with no error-amplifier fault and nothing latched has `pg_status`=1, `pgood_pull_low`=0 and `out_disable`=0, whatever the voltage comparators report.
- R6: A running slave that samples `ea_fault`=1 has `out_disable`=1 and `ov_flag`=1 in the next cycle.
- R7: While a slave is tripped by an error-amplifier fault, `pg_status` is 0 and `pgood_pull_low` is 0, so the pin stays released.
- R8: When `ov_resp`=2'b00 (ignore), a slave's `out_disable` and `ov_flag` return to 0 in the cycle after `ea_fault` clears, and `pg_status` returns to 1.
- R9: For any `ov_resp` other than 2'b00, a slave that has tripped stays tripped after `ea_fault` clears. The trip clears only after `run_en` has been sampled low, and the channel then reports power good again once it runs with no fault present.
- R10: A slave sampled with `run_en` low has `pgood_pull_low`=1, `pg_status`=0, `out_disable`=0 and `ov_flag`=0, even if `ea_fault` is high.
- R11: While `rst_n` is low, and on the first edge after reset, the outputs hold `pgood_pull_low`=1 and all other outputs at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_en | input | 1 | Channel commanded and enabled to run |
| is_master | input | 1 | 1 = master role, 0 = slave role |
| ton_dly_done | input | 1 | Turn-on delay has expired |
| ton_rise_done | input | 1 | Turn-on rise ramp is complete |
| ton_max_done | input | 1 | Turn-on maximum fault timer has elapsed |
| oc_hit | input | 1 | Overcurrent limit has been reached |
| toff_fall_busy | input | 1 | Turn-off fall ramp is in progress |
| vout_above_uv | input | 1 | Output voltage is above the UV limit |
| vout_below_ov | input | 1 | Output voltage is below the OV limit |
| ea_fault | input | 1 | Shared compensation voltage is too high |
| ov_resp | input | 2 | OV fault response; 2'b00 = ignore |
| pgood_pull_low | output | 1 | 1 = drive the power-good pin low, 0 = release it |
| pg_status | output | 1 | Status power-good bit |
| ov_flag | output | 1 | OV indication raised by an error-amplifier trip |
| out_disable | output | 1 | Request to disable the channel output |
| uv_unmask | output | 1 | UV faults and warnings may be reported |

## Verification
Each cycle, the assertions check the relations that one sampled cycle fixes. These are the UV gate, the master's voltage window and the link between its pin and its status bit, the slave's immediate trip and released pin, the outputs of a slave that is switched off, and the reset values. The persistence of a latched trip needs the bench's sequences. This covers a trip that outlives its fault, one that clears only after the channel is switched off and on, and one that recovers at once under the ignore response. The bench also shows that a master ignores the error-amplifier input and that a slave ignores the voltage comparators.

// File: rtl/pgm_pkg.sv
// Package: shared types for the power-good / UV mask block.
// Assumes: the OV-response code is two bits wide, and 2'b00 is the only
// code that lets a slave recover on its own.
package pgm_pkg;
    localparam int OVR_W = 2;

    typedef enum logic [OVR_W-1:0] {
        OVR_IGNORE    = 2'b00,
        OVR_SHUTDOWN  = 2'b01,
        OVR_RETRY     = 2'b10,
        OVR_LATCH_OFF = 2'b11
    } ovr_e;

    // Registered output bundle of the block.
    typedef struct packed {
        logic pull_low;
        logic pg;
        logic ov;
        logic dis;
        logic uv;
    } pg_out_t;

    localparam pg_out_t PG_OUT_RST = '{pull_low: 1'b1, pg: 1'b0, ov: 1'b0,
                                       dis: 1'b0, uv: 1'b0};
endpackage

// File: rtl/pgm_uv_gate.sv
// Module: UV reporting gate. Reporting is allowed only while the channel
// runs and every start-up readiness bit is set.
// Assumes: the caller maps each condition to an active-high "ready" bit.
module pgm_uv_gate #(
    parameter int N_COND = 5
) (
    input  logic              run_en,
    input  logic [N_COND-1:0] ready,
    output logic              unmask
);
    logic [N_COND:0] chain;

    assign chain[0] = run_en;

    // One AND stage per readiness condition.
    for (genvar i = 0; i < N_COND; i++) begin : g_and
        assign chain[i+1] = chain[i] & ready[i];
    end

    assign unmask = chain[N_COND];
endmodule

// File: rtl/pgm_ea_latch.sv
// Module: slave trip latch for error-amplifier faults when the OV
// response is not "ignore". The latch clears while the channel is off.
// Assumes: a synchronous active-low reset, and a role bit that is static
// while the channel runs.
module pgm_ea_latch
    import pgm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             is_slave,
    input  logic             ea_fault,
    input  logic [OVR_W-1:0] ov_resp,
    output logic             lock_nxt
);
    logic lock_q;
    logic set_c;

    // Set term: a running slave with a fault and a non-ignore response.
    always_comb set_c = is_slave & run_en & ea_fault & (ovr_e'(ov_resp) != OVR_IGNORE);

    // Next state: clear when off or master, otherwise hold or set.
    always_comb lock_nxt = (run_en & is_slave) ? (lock_q | set_c) : 1'b0;

    // State register for the latched trip.
    always_ff @(posedge clk) begin
        if (!rst_n) lock_q <= 1'b0;
        else        lock_q <= lock_nxt;
    end
endmodule

// File: rtl/pgm_role_eval.sv
// Module: works out the power-good, pin, OV and disable results for the
// master or slave role from the sampled inputs and the next latch state.
// Purely combinational; the top registers the results.
module pgm_role_eval
    import pgm_pkg::*;
(
    input  logic    is_master,
    input  logic    run_en,
    input  logic    in_window,
    input  logic    ea_fault,
    input  logic    lock_nxt,
    input  logic    uv_ok,
    output pg_out_t res
);
    logic trip;

    // A slave trips on a live fault or on a latched one, but only while it runs.
    always_comb trip = ~is_master & run_en & (ea_fault | lock_nxt);

    // Result selection per role.
    always_comb begin
        res.uv  = uv_ok;
        res.ov  = trip;
        res.dis = trip;
        if (is_master) begin
            res.pg       = run_en & in_window;
            res.pull_low = ~(run_en & in_window);
        end else begin
            res.pg       = run_en & ~trip;
            res.pull_low = ~run_en;
        end
    end
endmodule

// File: rtl/pgood_uvmask.sv
// Module: top of the channel power-good and UV mask logic. It samples all
// inputs on the rising clock edge and registers every output.
// Assumes: the inputs are synchronous to clk; the reset is synchronous and
// active low, and it pulls the pin low until the first evaluation.
module pgood_uvmask
    import pgm_pkg::*;
#(
    parameter int N_START = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic             is_master,
    input  logic             ton_dly_done,
    input  logic             ton_rise_done,
    input  logic             ton_max_done,
    input  logic             oc_hit,
    input  logic             toff_fall_busy,
    input  logic             vout_above_uv,
    input  logic             vout_below_ov,
    input  logic             ea_fault,
    input  logic [OVR_W-1:0] ov_resp,
    output logic             pgood_pull_low,
    output logic             pg_status,
    output logic             ov_flag,
    output logic             out_disable,
    output logic             uv_unmask
);
    logic [N_START-1:0] ready;
    logic               uv_ok;
    logic               lock_nxt;
    pg_out_t            res;
    pg_out_t            out_q;

    // Map the start-up conditions to active-high readiness bits.
    always_comb ready = {ton_dly_done, ton_rise_done, ton_max_done,
                         ~oc_hit, ~toff_fall_busy};

    pgm_uv_gate #(.N_COND(N_START)) u_gate (
        .run_en (run_en),
        .ready  (ready),
        .unmask (uv_ok)
    );

    pgm_ea_latch u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_en   (run_en),
        .is_slave (~is_master),
        .ea_fault (ea_fault),
        .ov_resp  (ov_resp),
        .lock_nxt (lock_nxt)
    );

    pgm_role_eval u_eval (
        .is_master (is_master),
        .run_en    (run_en),
        .in_window (vout_above_uv & vout_below_ov),
        .ea_fault  (ea_fault),
        .lock_nxt  (lock_nxt),
        .uv_ok     (uv_ok),
        .res       (res)
    );

    // Output register; reset holds the pin low.
    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= PG_OUT_RST;
        else        out_q <= res;
    end

    assign pgood_pull_low = out_q.pull_low;
    assign pg_status      = out_q.pg;
    assign ov_flag        = out_q.ov;
    assign out_disable    = out_q.dis;
    assign uv_unmask      = out_q.uv;
endmodule

// File: rtl/pgm_checker.sv
// Module: assertion checker for pgood_uvmask, attached with a bind.
// It relates each registered output to the inputs sampled one edge earlier.
module pgm_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       run_en,
    input logic       is_master,
    input logic       ton_dly_done,
    input logic       ton_rise_done,
    input logic       ton_max_done,
    input logic       oc_hit,
    input logic       toff_fall_busy,
    input logic       vout_above_uv,
    input logic       vout_below_ov,
    input logic       ea_fault,
    input logic       pgood_pull_low,
    input logic       pg_status,
    input logic       ov_flag,
    input logic       out_disable,
    input logic       uv_unmask
);
    a_r1_masked_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(run_en) |-> !uv_unmask);

    a_r2_gate_open: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> uv_unmask == $past(run_en && ton_dly_done && ton_rise_done
            && ton_max_done && !oc_hit && !toff_fall_busy));

    a_r3_master_window: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(is_master) |->
            pg_status == $past(run_en && vout_above_uv && vout_below_ov)
            && !ov_flag && !out_disable);

    a_r4_master_pin: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(is_master) |-> pgood_pull_low == !pg_status);

    a_r6_slave_trip: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(!is_master && run_en && ea_fault) |->
            out_disable && ov_flag);

    a_r7_slave_pin_released: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(!is_master && run_en) && out_disable |->
            !pg_status && !pgood_pull_low);

    a_r10_slave_off: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(!is_master && !run_en) |->
            pgood_pull_low && !pg_status && !out_disable && !ov_flag);

    a_r11_reset_state: assert property (@(posedge clk)
        !rst_n |=> pgood_pull_low && !pg_status && !ov_flag && !out_disable && !uv_unmask);
endmodule

bind pgood_uvmask pgm_checker u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .run_en         (run_en),
    .is_master      (is_master),
    .ton_dly_done   (ton_dly_done),
    .ton_rise_done  (ton_rise_done),
    .ton_max_done   (ton_max_done),
    .oc_hit         (oc_hit),
    .toff_fall_busy (toff_fall_busy),
    .vout_above_uv  (vout_above_uv),
    .vout_below_ov  (vout_below_ov),
    .ea_fault       (ea_fault),
    .pgood_pull_low (pgood_pull_low),
    .pg_status      (pg_status),
    .ov_flag        (ov_flag),
    .out_disable    (out_disable),
    .uv_unmask      (uv_unmask)
);

// File: tb/sim_pgood_uvmask.sv
// Bench: scoreboard for pgood_uvmask. The driver applies inputs on the
// falling edge and queues the outputs expected after the next rising edge.
// The monitor pops the queue 1 ns after each rising edge and compares.
`timescale 1ns/100ps
module sim_pgood_uvmask;
    typedef struct packed {
        logic pl;
        logic pg;
        logic ov;
        logic dis;
        logic uv;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run_en = 1'b0, is_master = 1'b1;
    logic       ton_dly_done = 1'b0, ton_rise_done = 1'b0, ton_max_done = 1'b0;
    logic       oc_hit = 1'b0, toff_fall_busy = 1'b0;
    logic       vout_above_uv = 1'b0, vout_below_ov = 1'b0, ea_fault = 1'b0;
    logic [1:0] ov_resp = 2'b00;
    logic       pgood_pull_low, pg_status, ov_flag, out_disable, uv_unmask;

    exp_t  q_exp[$];
    string q_tag[$];
    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done = 1'b0;

    always #2.5 clk = ~clk;

    pgood_uvmask u0 (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .is_master(is_master),
        .ton_dly_done(ton_dly_done), .ton_rise_done(ton_rise_done),
        .ton_max_done(ton_max_done), .oc_hit(oc_hit), .toff_fall_busy(toff_fall_busy),
        .vout_above_uv(vout_above_uv), .vout_below_ov(vout_below_ov),
        .ea_fault(ea_fault), .ov_resp(ov_resp),
        .pgood_pull_low(pgood_pull_low), .pg_status(pg_status), .ov_flag(ov_flag),
        .out_disable(out_disable), .uv_unmask(uv_unmask)
    );

    // Driver: the caller has already set the inputs after a falling edge;
    // queue the expectation for the next rising edge, then wait a cycle.
    task automatic step(input logic pl, input logic pg, input logic ov,
                        input logic dis, input logic uv, input string tag);
        q_exp.push_back('{pl: pl, pg: pg, ov: ov, dis: dis, uv: uv});
        q_tag.push_back(tag);
        @(negedge clk);
    endtask

    // Monitor: compare the outputs after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q_exp.size() != 0) begin
                exp_t  e;
                exp_t  a;
                string t;
                e = q_exp.pop_front();
                t = q_tag.pop_front();
                a = '{pl: pgood_pull_low, pg: pg_status, ov: ov_flag,
                      dis: out_disable, uv: uv_unmask};
                n_cmp++;
                if (a !== e) begin
                    n_bad++;
                    $display("FAIL %s: actual pl/pg/ov/dis/uv=%b expected %b", t, a, e);
                end
            end
        end
    end

    // Watchdog: count an expired run as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    // Stimulus sequence.
    initial begin
        @(negedge clk);
        run_en = 1; is_master = 1; vout_above_uv = 1; vout_below_ov = 1;
        ton_dly_done = 1; ton_rise_done = 1; ton_max_done = 1;
        step(1, 0, 0, 0, 0, "R11 reset hold");
        step(1, 0, 0, 0, 0, "R11 reset hold 2");
        rst_n = 1;
        step(0, 1, 0, 0, 1, "R3 R2 master good, gate open");
        oc_hit = 1;
        step(0, 1, 0, 0, 0, "R2 overcurrent masks UV");
        oc_hit = 0; toff_fall_busy = 1;
        step(0, 1, 0, 0, 0, "R2 fall ramp masks UV");
        toff_fall_busy = 0; ton_max_done = 0;
        step(0, 1, 0, 0, 0, "R2 max timer not elapsed");
        ton_max_done = 1; ton_rise_done = 0;
        step(0, 1, 0, 0, 0, "R2 rise ramp not complete");
        ton_rise_done = 1; ton_dly_done = 0;
        step(0, 1, 0, 0, 0, "R2 delay not expired");
        ton_dly_done = 1; vout_above_uv = 0;
        step(1, 0, 0, 0, 1, "R3 R4 master below UV");
        vout_above_uv = 1; vout_below_ov = 0;
        step(1, 0, 0, 0, 1, "R3 R4 master above OV");
        vout_below_ov = 1; run_en = 0;
        step(1, 0, 0, 0, 0, "R1 R4 master off");
        run_en = 1; ea_fault = 1;
        step(0, 1, 0, 0, 1, "R3 master ignores EA fault");
        ea_fault = 0; is_master = 0; vout_above_uv = 0; vout_below_ov = 0;
        step(0, 1, 0, 0, 1, "R5 slave ignores voltages");
        ov_resp = 2'b00; ea_fault = 1;
        step(0, 0, 1, 1, 1, "R6 R7 slave EA trip (ignore)");
        step(0, 0, 1, 1, 1, "R7 slave trip held");
        ea_fault = 0;
        step(0, 1, 0, 0, 1, "R8 ignore response recovers");
        ov_resp = 2'b01; ea_fault = 1;
        step(0, 0, 1, 1, 1, "R6 R7 slave EA trip (latching)");
        ea_fault = 0;
        step(0, 0, 1, 1, 1, "R9 latched after EA clears");
        ov_resp = 2'b00;
        step(0, 0, 1, 1, 1, "R9 still latched");
        run_en = 0;
        step(1, 0, 0, 0, 0, "R10 R1 slave off clears trip");
        run_en = 1;
        step(0, 1, 0, 0, 1, "R9 re-enabled after off/on");
        run_en = 0; ea_fault = 1; ov_resp = 2'b11;
        step(1, 0, 0, 0, 0, "R10 slave off with EA fault");
        run_en = 1; ea_fault = 0;
        step(0, 1, 0, 0, 1, "R10 R5 no latch while off");
        rst_n = 0;
        step(1, 0, 0, 0, 0, "R11 reset mid-run");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule